// File: doc/BRIEF.md
# Vertical Sync Window and Flywheel

This block sits in a display timing path and turns a noisy or unreliable vertical sync input into a clean, line-aligned vertical pulse. It counts horizontal line strobes since the last pulse it produced. An incoming vertical sync edge is accepted only when it falls inside a window set by programmable minimum and maximum line counts. If no edge is accepted before the maximum is reached, the block makes a pulse of its own at that line.

Each accepted external field length is compared with a stored length. After a run of identical fields the block switches to internal (flywheel) timing. In that mode it produces a pulse every stored number of lines, whatever the input does. While in flywheel mode it watches whether the external edge still lands on the internal pulse line. After a set number of consecutive fields where it does not, the block goes back to following the external sync and starts learning the field length again.

Top module: `vsync_flywheel`

## Requirements
- R1: The line index is the number of line strobes since the last output pulse, counting the current strobe. In external mode, a rising edge of `vsync_in` seen during a line, with a line index at or above `min_lines`, makes `vsync_out` go high on the clock after that line's strobe.
- R2: In external mode, a rising edge whose line index is below `min_lines` produces no output pulse and does not restart the line count.
- R3: In external mode, if no edge has been accepted when the line index reaches `max_lines`, an artificial pulse is produced on that strobe. It also clears the run of matching fields.
- R4: Each accepted field length is compared with the stored length. A different length replaces the stored value and clears the run. After 4 consecutive accepted fields equal to the stored length, `int_mode` goes to 1 on the strobe of the 4th.
- R5: In internal mode, a pulse is produced whenever the line index equals the stored length. External edges on other lines produce no pulse.
- R6: In internal mode, a field counts as a miss when no external edge was seen during its pulse line. A field with an edge there clears the miss count. On the 3rd consecutive miss, `int_mode` returns to 0 on that field's pulse strobe, and the line count restarts there.
- R7: `vsync_out` changes only on the clock after a line strobe and stays high for exactly one line. After reset, `vsync_out` and `int_mode` are 0 and the line count is zero. `min_lines` and `max_lines` are 10-bit values (200 and 700 lines typical).
- R8: Only rising edges of `vsync_in` count. A level held high across many lines counts once, on the line where it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-clock strobe per horizontal line |
| vsync_in | input | 1 | Raw vertical sync level |
| min_lines | input | 10 | Earliest line index at which an edge is accepted |
| max_lines | input | 10 | Line index at which an artificial pulse is inserted |
| vsync_out | output | 1 | Cleaned vertical pulse, one line long |
| int_mode | output | 1 | 1 when flywheel timing is active, 0 when following the input |

## Verification
The bench checks that an edge arriving too early is dropped and does not restart the count. A design that restarted the count there would shift every later pulse. It checks the exact line of the artificial pulse, using both small limits and 10-bit limits, where an off-by-one would show up one line early or late. It also checks that an artificial pulse breaks the confirmation run: a design that kept the run would enter flywheel mode one field early. Finally, it checks that one good field in between resets the miss hysteresis, that off-line edges in flywheel mode are ignored, and that a held-high input does not re-trigger.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

   typedef enum logic {
      SYNC_EXT = 1'b0,
      SYNC_INT = 1'b1
   } sync_mode_e;

endpackage

// File: rtl/vsf_edge_latch.sv
// Captures a rising edge of the raw vertical sync anywhere inside a line
// and presents it until the line strobe consumes it.
module vsf_edge_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync_in,
   input  logic line_stb,
   output logic ext_evt
);

   logic vs_s;
   logic vs_q;
   logic pend_q;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign vs_s = vsync_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_q <= '0;
            end else begin
               sr_q[0] <= vsync_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sr_q[i] <= sr_q[i-1];
               end
            end
         end
         assign vs_s = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise    = vs_s & ~vs_q;
   assign ext_evt = pend_q | rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         vs_q   <= vs_s;
         pend_q <= line_stb ? 1'b0 : (pend_q | rise);
      end
   end

endmodule

// File: rtl/vsf_line_cnt.sv
// Counts line strobes since the last output pulse; saturates at all ones.
module vsf_line_cnt #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  logic              restart,
   output logic [LINE_W-1:0] cnt_q,
   output logic [LINE_W-1:0] line_idx
);

   localparam logic [LINE_W-1:0] CNT_TOP = {LINE_W{1'b1}};

   assign line_idx = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + LINE_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (line_stb) begin
         cnt_q <= restart ? '0 : line_idx;
      end
   end

endmodule

// File: rtl/vsf_lock.sv
// Field-length learning, confirmation run and miss hysteresis.
module vsf_lock
   import vsf_pkg::*;
#(
   parameter int LINE_W         = 10,
   parameter int CONFIRM_FIELDS = 4,
   parameter int MISS_FIELDS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_ext,
   input  logic              art_pulse,
   input  logic              fly_pulse,
   input  logic              ext_evt,
   input  logic [LINE_W-1:0] line_idx,
   output sync_mode_e        mode_q,
   output logic [LINE_W-1:0] stored_q
);

   localparam int CW = $clog2(CONFIRM_FIELDS + 1);
   localparam int MW = $clog2(MISS_FIELDS + 1);
   localparam logic [CW-1:0] CONF_LAST = CW'(CONFIRM_FIELDS - 1);
   localparam logic [MW-1:0] MISS_LAST = MW'(MISS_FIELDS - 1);

   logic [CW-1:0] match_q;
   logic [MW-1:0] miss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= SYNC_EXT;
         stored_q <= '0;
         match_q  <= '0;
         miss_q   <= '0;
      end else if (acc_ext) begin
         if (line_idx == stored_q) begin
            if (match_q == CONF_LAST) begin
               mode_q  <= SYNC_INT;
               match_q <= '0;
               miss_q  <= '0;
            end else begin
               match_q <= match_q + CW'(1);
            end
         end else begin
            stored_q <= line_idx;
            match_q  <= '0;
         end
      end else if (art_pulse) begin
         match_q <= '0;
      end else if (fly_pulse) begin
         if (ext_evt) begin
            miss_q <= '0;
         end else if (miss_q == MISS_LAST) begin
            mode_q  <= SYNC_EXT;
            miss_q  <= '0;
            match_q <= '0;
         end else begin
            miss_q <= miss_q + MW'(1);
         end
      end
   end

endmodule

// File: rtl/vsync_flywheel.sv
module vsync_flywheel
   import vsf_pkg::*;
#(
   parameter int LINE_W         = 10,
   parameter int CONFIRM_FIELDS = 4,
   parameter int MISS_FIELDS    = 3,
   parameter int SYNC_STAGES    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_stb,
   input  logic              vsync_in,
   input  logic [LINE_W-1:0] min_lines,
   input  logic [LINE_W-1:0] max_lines,
   output logic              vsync_out,
   output logic              int_mode
);

   generate
      if (LINE_W < 2 || LINE_W > 16) begin : g_bad_line_w
         $error("vsync_flywheel: LINE_W must lie in 2..16");
      end
      if (CONFIRM_FIELDS < 1) begin : g_bad_confirm
         $error("vsync_flywheel: CONFIRM_FIELDS must be at least 1");
      end
      if (MISS_FIELDS < 1) begin : g_bad_miss
         $error("vsync_flywheel: MISS_FIELDS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("vsync_flywheel: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              ext_evt;
   logic [LINE_W-1:0] cnt_q;
   logic [LINE_W-1:0] line_idx;
   logic [LINE_W-1:0] stored;
   sync_mode_e        mode;
   logic              acc_ext;
   logic              art_pulse;
   logic              fly_pulse;
   logic              fire;

   vsf_edge_latch #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .vsync_in (vsync_in),
      .line_stb (line_stb),
      .ext_evt  (ext_evt)
   );

   vsf_line_cnt #(
      .LINE_W(LINE_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb),
      .restart  (fire),
      .cnt_q    (cnt_q),
      .line_idx (line_idx)
   );

   always_comb begin
      acc_ext   = line_stb && (mode == SYNC_EXT) && ext_evt && (line_idx >= min_lines);
      art_pulse = line_stb && (mode == SYNC_EXT) && !acc_ext && (line_idx >= max_lines);
      fly_pulse = line_stb && (mode == SYNC_INT) && (line_idx == stored);
      fire      = acc_ext || art_pulse || fly_pulse;
   end

   vsf_lock #(
      .LINE_W        (LINE_W),
      .CONFIRM_FIELDS(CONFIRM_FIELDS),
      .MISS_FIELDS   (MISS_FIELDS)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_ext   (acc_ext),
      .art_pulse (art_pulse),
      .fly_pulse (fly_pulse),
      .ext_evt   (ext_evt),
      .line_idx  (line_idx),
      .mode_q    (mode),
      .stored_q  (stored)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsync_out <= 1'b0;
      end else if (line_stb) begin
         vsync_out <= fire;
      end
   end

   assign int_mode = (mode == SYNC_INT);

endmodule

// File: rtl/vsf_checker.sv
module vsf_checker #(
   parameter int LINE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_stb,
   input logic              vsync_out,
   input logic              int_mode,
   input logic [LINE_W-1:0] cnt_q,
   input logic [LINE_W-1:0] max_lines
);

   // R7: output moves only after a strobe
   assert_out_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(line_stb) |-> $stable(vsync_out));

   // R1: a pulse starts only on a strobe
   assert_rise_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vsync_out) |-> $past(line_stb));

   // R4: flywheel entry coincides with an accepted pulse
   assert_enter_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_mode) |-> vsync_out);

   // R6: return to external timing coincides with a flywheel pulse
   assert_leave_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_mode) |-> vsync_out);

   // R3: in external mode the count never reaches the maximum
   assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && max_lines != '0) |-> (cnt_q < max_lines));

endmodule

bind vsync_flywheel vsf_checker #(.LINE_W(LINE_W)) u_vsf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_stb  (line_stb),
   .vsync_out (vsync_out),
   .int_mode  (int_mode),
   .cnt_q     (cnt_q),
   .max_lines (max_lines)
);

// File: tb/vsync_flywheel_bench.sv
`timescale 1ns/1ps
module vsync_flywheel_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       line_stb;
   logic       vsync_in;
   logic [9:0] min_lines;
   logic [9:0] max_lines;
   logic       vsync_out;
   logic       int_mode;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit vs_hold = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vsync_flywheel u_vsync_flywheel (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_stb  (line_stb),
      .vsync_in  (vsync_in),
      .min_lines (min_lines),
      .max_lines (max_lines),
      .vsync_out (vsync_out),
      .int_mode  (int_mode)
   );

   // behavioural reference model
   int m_cnt = 0, m_stored = 0, m_match = 0, m_miss = 0;
   bit m_int = 0, m_vout = 0, m_prev = 0, m_pend = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_stored = 0; m_match = 0; m_miss = 0;
         m_int = 0; m_vout = 0; m_prev = 0; m_pend = 0;
      end else begin
         bit ext;
         int idx;
         bit hit;
         if (vsync_in && !m_prev) m_pend = 1;
         m_prev = vsync_in;
         ext = m_pend;
         if (line_stb) begin
            idx = m_cnt + 1;
            hit = 0;
            if (!m_int) begin
               if (ext && idx >= int'(min_lines)) begin
                  hit = 1;
                  if (idx == m_stored) begin
                     m_match++;
                     if (m_match == 4) begin m_int = 1; m_match = 0; m_miss = 0; end
                  end else begin
                     m_stored = idx; m_match = 0;
                  end
               end else if (idx >= int'(max_lines)) begin
                  hit = 1; m_match = 0;
               end
            end else if (idx == m_stored) begin
               hit = 1;
               if (ext) m_miss = 0;
               else begin
                  m_miss++;
                  if (m_miss == 3) begin m_int = 0; m_miss = 0; m_match = 0; end
               end
            end
            m_cnt = hit ? 0 : idx;
            m_vout = hit;
            m_pend = 0;
         end
      end
   end

   // cycle compare (R7 timing of every output change)
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         checks++;
         if (vsync_out !== m_vout || int_mode !== m_int) begin
            errors++;
            $display("FAIL R7 cycle model: vsync_out=%0d int_mode=%0d expected %0d %0d",
                     vsync_out, int_mode, m_vout, m_int);
         end
      end
   end

   task automatic check_val(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic one_line(input bit vs);
      @(negedge clk); vsync_in = vs_hold | vs;
      @(negedge clk); vsync_in = vs_hold;
      @(negedge clk); line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
      if (vsync_out) pulses++;
   endtask

   task automatic field(input int len, input int va, input int vb);
      for (int i = 1; i <= len; i++) one_line((i == va) || (i == vb));
   endtask

   initial begin
      #(100000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; line_stb = 1'b0; vsync_in = 1'b0;
      min_lines = 10'd20; max_lines = 10'd60;
      repeat (4) @(negedge clk);
      check_val("R7 reset vsync_out", vsync_out, 0);
      check_val("R7 reset int_mode", int_mode, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // learning run: one setting field then four matching ones
      repeat (4) field(40, 40, 0);
      check_val("R4 not yet internal after 4 fields", int_mode, 0);
      check_val("R1 accepted pulses", pulses, 4);
      field(40, 40, 0);
      check_val("R4 internal after 4 matches", int_mode, 1);
      repeat (2) field(40, 40, 0);
      check_val("R5 flywheel pulses", pulses, 7);

      // off-line edge ignored, miss counting with a good field in between
      field(40, 30, 0);
      check_val("R5 off-line edge adds no pulse", pulses, 8);
      field(40, 0, 0);
      field(40, 40, 0);
      repeat (2) field(40, 0, 0);
      check_val("R6 good field cleared misses", int_mode, 1);
      field(40, 0, 0);
      check_val("R6 third miss returns to external", int_mode, 0);
      check_val("R6 pulses kept on flywheel line", pulses, 13);

      // early edge dropped, accepted one at 40
      field(40, 10, 40);
      check_val("R2 early edge dropped", pulses, 14);
      one_line(1'b0);
      check_val("R1 pulse one line long", vsync_out, 0);

      // artificial pulse at max (count already 1)
      field(58, 0, 0);
      check_val("R3 no pulse before max", vsync_out, 0);
      one_line(1'b0);
      check_val("R3 artificial pulse at max", vsync_out, 1);
      repeat (3) field(40, 40, 0);
      check_val("R3 artificial pulse cleared run", int_mode, 0);
      field(40, 40, 0);
      check_val("R4 internal after new run", int_mode, 1);
      check_val("R4 pulse total", pulses, 19);
      repeat (3) field(40, 0, 0);
      check_val("R6 back to external", int_mode, 0);

      // 10-bit limits
      min_lines = 10'd200; max_lines = 10'd700;
      field(250, 150, 250);
      check_val("R2 wide window accepted only at 250", pulses, 23);
      field(699, 0, 0);
      check_val("R3 wide no pulse at 699", vsync_out, 0);
      one_line(1'b0);
      check_val("R3 wide artificial at 700", vsync_out, 1);

      // held-high level counts once
      min_lines = 10'd20; max_lines = 10'd60;
      vs_hold = 1'b1;
      field(59, 0, 0);
      check_val("R8 held level no retrigger", vsync_out, 0);
      one_line(1'b0);
      check_val("R8 artificial after held level", vsync_out, 1);
      vs_hold = 1'b0;
      check_val("R8 pulse total", pulses, 25);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule